// File: doc/BRIEF.md
# SMBus Alert Responder

This block is the slave side of an SMBus alert. When an internal service request is active, alert mode is selected and a host-written disable flag is clear, the block pulls an open-drain alert line low. A host that sees the alert reads from the Alert Response Address. The block acknowledges that read and sends its own 7-bit address. While it sends, it checks each released bit against the bus. If its whole address goes out intact, it sets the disable flag, and this releases the alert line. The host must clear the flag again to re-arm the alert. A device that loses arbitration stops driving for the rest of the byte and keeps its alert asserted.

When alert mode is not selected, the alert pin carries an ordinary output value. This value is either the internal logic output or a general-purpose register bit. The bus inputs are synchronised into the system clock. START and STOP are recognised as data edges while the clock line is high. The block changes its data pull-down only while the synchronised clock line is low.

Top module: `smb_alert_resp`

## Requirements
- R1: After reset the disable flag is 1, so no alert is asserted even with a pending request, and both `sda_pd_o` and `alert_pd_o` are 0 (released).
- R2: With `mode_alert_i`=1, `alert_pd_o` is 1 exactly when `event_req_i`=1 and the disable flag is 0.
- R3: With `mode_alert_i`=0, `alert_pd_o` is the inverse of the selected pin value. `out_sel_i`=1 selects `gp_val_i` and `out_sel_i`=0 selects `logic_val_i`.
- R4: A one-cycle pulse on `dis_wr_i` loads `dis_wdata_i` into the disable flag. Writing 0 arms the alert.
- R5: An address byte of 0x19 (Alert Response Address 0001100 followed by R/W=1) received while the alert is asserted is acknowledged: `sda_pd_o`=1 during the ninth clock.
- R6: No acknowledge is given, and SDA stays released, for any other address byte, for 0x18 (ARA with write), or while the alert is not asserted.
- R7: After the acknowledge, the data byte carries `OWN_ADDR` most significant bit first in bits 7..1. Bit 0 is left released (reads 1).
- R8: If every address bit went out unopposed, the disable flag becomes 1 at the end of the byte and `alert_pd_o` returns to 0.
- R9: If a bit the block releases is seen as 0, the block drives no further bits of that byte, the bus carries the winner's address, and the disable flag and `alert_pd_o` stay unchanged.
- R10: A STOP, or a repeated START, in the middle of a transaction abandons it without changing the disable flag. A repeated START begins a fresh address byte.
- R11: `sda_pd_o` changes only on cycles where the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pd_o | output | 1 | Pull data line low when 1 |
| alert_pd_o | output | 1 | Pull alert/output pin low when 1 |
| event_req_i | input | 1 | Internal request for service |
| mode_alert_i | input | 1 | 1: pin acts as alert, 0: ordinary output |
| out_sel_i | input | 1 | Ordinary output source: 1 register bit, 0 logic output |
| logic_val_i | input | 1 | Internal logic output value |
| gp_val_i | input | 1 | General-purpose register value |
| dis_wr_i | input | 1 | Write strobe for the disable flag |
| dis_wdata_i | input | 1 | Value written to the disable flag |

## Verification
The bench models a second alerting device on the data line. One run uses a lower address, which must beat this block. A design that kept driving after losing would corrupt the winner's address. A design that did not check arbitration would wrongly release its alert. Another run uses an address that differs only in the last bit, where this block must still win. Address bytes that are close to the ARA (the write form), and an ARA read made while the flag is set, must draw no acknowledge. A design that decoded only seven bits or ignored the alert state would acknowledge them. A STOP and a repeated START in the middle of the address byte must leave the alert asserted and allow the next read. A design that reset the flag on abort, or that stalled in a stale state, would show a wrong alert level or miss the following acknowledge.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  localparam logic [7:0] ARA_READ_BYTE = 8'b0001_1001;

  typedef enum logic [2:0] {
    RS_IDLE = 3'd0,
    RS_ADDR = 3'd1,
    RS_ACK  = 3'd2,
    RS_TX   = 3'd3,
    RS_MACK = 3'd4,
    RS_SKIP = 3'd5
  } resp_state_t;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '1;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_ara_fsm.sv
module smb_ara_fsm
  import smb_alert_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic start_c,
  input  logic stop_c,
  input  logic alert_on,
  output logic sda_drv_o,
  output logic win_o,
  output logic lost_o,
  output logic idle_o
);
  localparam int CNT_W   = 4;
  localparam int LAST_AB = 7;

  resp_state_t      st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]       sh_q, sh_n;
  logic             drv_q, drv_n;
  logic             lost_q, lost_n;
  logic             win_q, win_n;
  logic [2:0]       bit_idx;

  assign bit_idx = 3'd6 - cnt_q[2:0];

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    drv_n  = drv_q;
    lost_n = lost_q;
    win_n  = 1'b0;
    if (stop_c) begin
      st_n  = RS_IDLE;
      drv_n = 1'b0;
    end else if (start_c) begin
      st_n   = RS_ADDR;
      cnt_n  = '0;
      sh_n   = '0;
      drv_n  = 1'b0;
      lost_n = 1'b0;
    end else begin
      case (st_q)
        RS_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(8)) begin
            if (sh_q == ARA_READ_BYTE && alert_on) begin
              st_n  = RS_ACK;
              drv_n = 1'b1;
            end else begin
              st_n = RS_SKIP;
            end
          end
        end
        RS_ACK: begin
          if (scl_fall) begin
            st_n   = RS_TX;
            cnt_n  = '0;
            lost_n = 1'b0;
            drv_n  = ~OWN_ADDR[6];
          end
        end
        RS_TX: begin
          if (scl_rise) begin
            if (!drv_q && !sda_s && cnt_q < CNT_W'(LAST_AB)) lost_n = 1'b1;
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == CNT_W'(8)) begin
              st_n  = RS_MACK;
              drv_n = 1'b0;
              win_n = ~lost_q;
            end else if (cnt_q < CNT_W'(LAST_AB)) begin
              drv_n = ~lost_q & ~OWN_ADDR[bit_idx];
            end else begin
              drv_n = 1'b0;
            end
          end
        end
        RS_MACK: begin
          if (scl_fall) st_n = RS_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      drv_q  <= 1'b0;
      lost_q <= 1'b0;
      win_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      drv_q  <= drv_n;
      lost_q <= lost_n;
      win_q  <= win_n;
    end
  end

  assign sda_drv_o = drv_q;
  assign win_o     = win_q;
  assign lost_o    = lost_q;
  assign idle_o    = (st_q == RS_IDLE);
endmodule

// File: rtl/smb_alert_resp.sv
module smb_alert_resp #(
  parameter logic [6:0] OWN_ADDR    = 7'h5A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pd_o,
  output logic alert_pd_o,
  input  logic event_req_i,
  input  logic mode_alert_i,
  input  logic out_sel_i,
  input  logic logic_val_i,
  input  logic gp_val_i,
  input  logic dis_wr_i,
  input  logic dis_wdata_i
);
  logic [1:0] bus_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_c, stop_c;
  logic       dis_bit, dis_bit_n;
  logic       alert_on;
  logic       ara_win, lost_w, idle_w;
  logic       pin_pd_n, pin_pd_q;

  smb_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  smb_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  assign alert_on = mode_alert_i & ~dis_bit & event_req_i;

  smb_ara_fsm #(.OWN_ADDR(OWN_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .alert_on(alert_on),
    .sda_drv_o(sda_pd_o), .win_o(ara_win), .lost_o(lost_w), .idle_o(idle_w)
  );

  always_comb begin
    dis_bit_n = dis_bit;
    if (ara_win)       dis_bit_n = 1'b1;
    else if (dis_wr_i) dis_bit_n = dis_wdata_i;
  end

  always_comb begin
    if (mode_alert_i) pin_pd_n = alert_on;
    else              pin_pd_n = ~(out_sel_i ? gp_val_i : logic_val_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_bit  <= 1'b1;
      pin_pd_q <= 1'b0;
    end else begin
      dis_bit  <= dis_bit_n;
      pin_pd_q <= pin_pd_n;
    end
  end

  assign alert_pd_o = pin_pd_q;
endmodule

// File: rtl/smb_alert_chk.sv
module smb_alert_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_pd_o,
  input logic alert_pd_o,
  input logic mode_alert_i,
  input logic event_req_i,
  input logic dis_wr_i,
  input logic dis_wdata_i,
  input logic dis_bit,
  input logic win,
  input logic scl_s,
  input logic lost,
  input logic idle
);
  assert_alert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_pd_o && $past(mode_alert_i)) |-> (!$past(dis_bit) && $past(event_req_i)));

  assert_flag_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_wr_i && !win) |=> (dis_bit == $past(dis_wdata_i)));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pd_o);

  assert_win_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win |=> dis_bit);

  assert_lost_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> !sda_pd_o);

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_wr_i && !win) |=> $stable(dis_bit));

  assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pd_o) |-> !$past(scl_s));
endmodule

bind smb_alert_resp smb_alert_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sda_pd_o(sda_pd_o), .alert_pd_o(alert_pd_o),
  .mode_alert_i(mode_alert_i), .event_req_i(event_req_i),
  .dis_wr_i(dis_wr_i), .dis_wdata_i(dis_wdata_i), .dis_bit(dis_bit),
  .win(ara_win), .scl_s(scl_s), .lost(lost_w), .idle(idle_w)
);

// File: tb/smb_alert_resp_tb.sv
`timescale 1ns/1ps
module smb_alert_resp_tb_top;
  localparam logic [6:0] OWN = 7'h5A;
  localparam int Q = 6;
  // vector fields: {mode, sel, logic, gp, event, wr, wdata, expected alert_pd}
  localparam logic [7:0] VEC [9] = '{
    8'b1_0_0_0_1_0_0_0,
    8'b1_0_0_0_1_1_0_1,
    8'b1_0_0_0_0_0_0_0,
    8'b0_0_1_0_1_0_0_0,
    8'b0_0_0_1_1_0_0_1,
    8'b0_1_0_1_1_0_0_0,
    8'b0_1_1_0_1_0_0_1,
    8'b1_0_0_0_1_1_1_0,
    8'b1_0_0_0_1_1_0_1
  };

  logic clk, rst_n;
  logic scl_m, sda_m, comp_pd;
  logic sda_pd_o, alert_pd_o;
  logic event_req_i, mode_alert_i, out_sel_i, logic_val_i, gp_val_i;
  logic dis_wr_i, dis_wdata_i;
  wire  sda_line = sda_m & ~sda_pd_o & ~comp_pd;
  int   errors = 0;
  int   checks = 0;

  smb_alert_resp #(.OWN_ADDR(OWN)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pd_o(sda_pd_o), .alert_pd_o(alert_pd_o),
    .event_req_i(event_req_i), .mode_alert_i(mode_alert_i),
    .out_sel_i(out_sel_i), .logic_val_i(logic_val_i), .gp_val_i(gp_val_i),
    .dis_wr_i(dis_wr_i), .dis_wdata_i(dis_wdata_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wc(Q); scl_m = 1'b1; wc(Q);
    sda_m = 1'b0; wc(Q); scl_m = 1'b0; wc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wc(Q); scl_m = 1'b1; wc(Q); sda_m = 1'b1; wc(Q);
  endtask

  task automatic bus_bit(input logic b, output logic seen, output logic dpd);
    sda_m = b; wc(Q); scl_m = 1'b1; wc(Q);
    seen = sda_line; dpd = sda_pd_o;
    wc(Q); scl_m = 1'b0; wc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic ack_pd);
    logic s, p;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s, p);
    bus_bit(1'b1, s, p);
    ack = ~s; ack_pd = p;
  endtask

  task automatic read_byte(input logic [6:0] comp, input logic use_comp,
                           output logic [7:0] got, output logic [7:0] pdm);
    logic s, p;
    for (int i = 0; i < 8; i++) begin
      comp_pd = use_comp && (i < 7) && !comp[6-i];
      bus_bit(1'b1, s, p);
      got[7-i] = s; pdm[7-i] = p;
    end
    comp_pd = 1'b0;
    bus_bit(1'b1, s, p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack, apd;
    logic [7:0] got, pdm;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; comp_pd = 1'b0;
    event_req_i = 1'b1; mode_alert_i = 1'b1; out_sel_i = 1'b0;
    logic_val_i = 1'b0; gp_val_i = 1'b0; dis_wr_i = 1'b0; dis_wdata_i = 1'b0;
    wc(4); rst_n = 1'b1; wc(4);
    chk(alert_pd_o == 1'b0, "R1 alert released", alert_pd_o, 0);
    chk(sda_pd_o == 1'b0, "R1 sda released", sda_pd_o, 0);

    // table walk over pin modes and flag writes (R2 R3 R4)
    for (int v = 0; v < 9; v++) begin
      {mode_alert_i, out_sel_i, logic_val_i, gp_val_i, event_req_i} = VEC[v][7:3];
      dis_wdata_i = VEC[v][1];
      if (VEC[v][2]) begin dis_wr_i = 1'b1; wc(1); dis_wr_i = 1'b0; end
      wc(3);
      chk(alert_pd_o == VEC[v][0], $sformatf("R2/R3/R4 vector %0d", v), alert_pd_o, VEC[v][0]);
    end

    // full winning response, no competitor (R5 R7 R8)
    bus_start(); send_byte(8'h19, ack, apd);
    chk(ack, "R5 ack on ARA read", ack, 1);
    chk(apd, "R5 sda_pd during ack", apd, 1);
    read_byte(7'h00, 1'b0, got, pdm);
    chk(got == {OWN, 1'b1}, "R7 address byte", got, {OWN, 1'b1});
    bus_stop(); wc(4);
    chk(alert_pd_o == 1'b0, "R8 alert released after win", alert_pd_o, 0);

    // flag is set now: ARA read must not be acknowledged (R6)
    bus_start(); send_byte(8'h19, ack, apd); bus_stop();
    chk(!ack, "R6 no ack while alert off", ack, 0);

    dis_wdata_i = 1'b0; dis_wr_i = 1'b1; wc(1); dis_wr_i = 1'b0; wc(3);
    chk(alert_pd_o == 1'b1, "R4 rearm", alert_pd_o, 1);

    bus_start(); send_byte(8'h18, ack, apd); bus_stop();
    chk(!ack, "R6 no ack for ARA write", ack, 0);
    bus_start(); send_byte(8'hA1, ack, apd); bus_stop();
    chk(!ack, "R6 no ack for other address", ack, 0);

    // aborts (R10)
    begin
      logic s, p;
      bus_start();
      bus_bit(1'b0, s, p); bus_bit(1'b0, s, p); bus_bit(1'b0, s, p); bus_bit(1'b1, s, p);
      bus_stop(); wc(4);
      chk(alert_pd_o == 1'b1, "R10 stop keeps alert", alert_pd_o, 1);
      bus_start();
      bus_bit(1'b1, s, p); bus_bit(1'b0, s, p); bus_bit(1'b1, s, p); bus_bit(1'b1, s, p);
    end
    bus_start(); send_byte(8'h19, ack, apd);
    chk(ack, "R10 ack after repeated start", ack, 1);

    // losing arbitration to a lower address (R9)
    read_byte(7'h52, 1'b1, got, pdm);
    chk(got == {7'h52, 1'b1}, "R9 bus carries winner", got, {7'h52, 1'b1});
    chk(pdm[3] == 1'b0, "R9 no drive after loss", pdm[3], 0);
    bus_stop(); wc(4);
    chk(alert_pd_o == 1'b1, "R9 alert kept after loss", alert_pd_o, 1);

    // competitor differing only in last bit: this block wins (R8)
    bus_start(); send_byte(8'h19, ack, apd);
    read_byte(7'h5B, 1'b1, got, pdm);
    chk(got == {OWN, 1'b1}, "R8 own address wins", got, {OWN, 1'b1});
    bus_stop(); wc(4);
    chk(alert_pd_o == 1'b0, "R8 alert released after close win", alert_pd_o, 0);
    chk(sda_pd_o == 1'b0, "R11 sda released at end", sda_pd_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule